// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a clock by a programmable integer ratio of the form P*SM + SS. It is built from three parts. The first is a dual-modulus prescaler that counts either P or P+1 input clocks per output edge. The second is a main counter that counts the prescaler cycles in one output period. The third is a swallow counter that keeps the prescaler in its longer P+1 mode for the first SS of those prescaler cycles. The remaining SM-SS prescaler cycles use the shorter P mode, so one output period lasts SS*(P+1) + (SM-SS)*P = P*SM + SS input clocks.

The modulus pair is chosen by a parameter. A high-band instance uses 32/33 and a low-band instance uses 8/9. The swallow field is 5 bits or 3 bits wide to match. The divided output is a single-clock pulse and is meant to feed a phase comparator. The enable input acts as a power-down control. While it is low, every counter is held at its starting point and no pulses are produced.

Both counters reload from the programming inputs at each period boundary. Software may therefore change SM and SS at any time without corrupting the period in progress.

Top module: `pulse_swallow_div`

## Requirements
- R1: Let the first clock edge at which `en` is sampled high be edge 1. Then `div_out` is high for the clock after edge P*SM+SS, and again after every further P*SM+SS edges.
- R2: With SS = 0 the output period is exactly P*SM clocks.
- R3: `div_out` is registered and is never high for two consecutive clocks.
- R4: A change of `sm_val` or `ss_val` partway through a period does not alter that period. The values present at the boundary edge, which is the edge that raises `div_out`, set the length of the next period. This also holds when the change arrives one clock before that edge.
- R5: While `en` is low, `div_out` stays low and the counters stay at their start state. After `en` returns high, the first pulse follows the R1 timing, counted from the re-enable.
- R6: After a synchronous active-high `rst`, `div_out` is low.
- R7: Parameter PRESC selects the modulus pair. PRESC = 32 gives 32/33 with a 5-bit `ss_val`, and PRESC = 8 gives 8/9 with a 3-bit `ss_val`. `sm_val` is 7 bits in both cases.
- R8: The extremes of the legal range give the exact ratio. These are SM = 5, SM = 127 and SS = min(P-1, SM-1). Inputs are legal when SM is between 5 and 127 and SS < SM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided-input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the divider in power-down |
| sm_val | input | 7 | Main count SM (5 to 127) |
| ss_val | input | $clog2(PRESC) | Swallow count SS (below SM and below PRESC) |
| div_out | output | 1 | One-clock pulse per full division period |

## Verification
The low-band divider is swept over every legal SS for SM from 5 to 20. This separates the P and P+1 contributions: an error in which prescaler cycles get swallowed shifts the pulse by a number of clocks that depends on SS. The high-band divider runs at SM values 5, 6, 7, 64 and 127 with SS values 0, 1, 4 and 31 where legal. This shows that the wider swallow field and the 32/33 pair scale correctly. The SS = 0 runs isolate the pure P*SM count. Mid-period reprogramming, including a change one clock before the boundary, shows that the old period completes and the new value applies at the next boundary. An enable dropped in mid-period shows that the counters restart cleanly.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    localparam int SM_W      = 7;
    localparam int SS_MAX_W  = 5;

    typedef enum logic {
        MOD_P  = 1'b0,
        MOD_P1 = 1'b1
    } modsel_e;

    typedef struct packed {
        logic [SM_W-1:0]     main_left;
        logic [SS_MAX_W-1:0] swal_left;
    } pgd_state_t;

    function automatic int swal_width(input int p);
        return $clog2(p);
    endfunction

    function automatic int presc_cnt_width(input int p);
        return $clog2(p + 1);
    endfunction

endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int P = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  pswal_pkg::modsel_e mode,
    output logic              tc
);
    import pswal_pkg::*;

    localparam int CW = presc_cnt_width(P);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last = (mode == MOD_P1) ? CW'(P) : CW'(P - 1);
        tc   = en && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tc) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/pgd_counters.sv
module pgd_counters #(
    parameter int P    = 32,
    parameter int SS_W = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [pswal_pkg::SM_W-1:0]    sm_in,
    input  logic [SS_W-1:0]               ss_in,
    input  logic                          tc,
    output pswal_pkg::modsel_e            mode,
    output logic                          boundary
);
    import pswal_pkg::*;

    pgd_state_t st;
    pgd_state_t fresh;

    always_comb begin
        fresh.main_left = sm_in;
        fresh.swal_left = SS_MAX_W'(ss_in);
        mode            = (st.swal_left != '0) ? MOD_P1 : MOD_P;
        boundary        = en && tc && (st.main_left == SM_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st <= fresh;
        end else if (tc) begin
            if (st.main_left == SM_W'(1)) begin
                st <= fresh;
            end else begin
                st.main_left <= st.main_left - SM_W'(1);
                if (st.swal_left != '0) begin
                    st.swal_left <= st.swal_left - SS_MAX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int  PRESC = 32,
    localparam int SS_W  = pswal_pkg::swal_width(PRESC)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [pswal_pkg::SM_W-1:0] sm_val,
    input  logic [SS_W-1:0]            ss_val,
    output logic                       div_out
);
    import pswal_pkg::*;

    modsel_e mode;
    logic    tc;
    logic    boundary;

    dm_prescaler #(.P(PRESC)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .mode (mode),
        .tc   (tc)
    );

    pgd_counters #(.P(PRESC), .SS_W(SS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sm_in    (sm_val),
        .ss_in    (ss_val),
        .tc       (tc),
        .mode     (mode),
        .boundary (boundary)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= 1'b0;
        end else begin
            div_out <= boundary;
        end
    end

endmodule

// File: rtl/pswal_checker.sv
module pswal_checker (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               div_out,
    input logic               boundary,
    input pswal_pkg::modsel_e mode
);
    import pswal_pkg::*;

    // R3: output pulse lasts one clock
    p_one_wide_r3: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // R3: a period boundary raises the registered output next clock
    p_boundary_reg_r3: assert property (@(posedge clk) disable iff (rst)
        boundary |=> div_out);

    // R1: every swallow cycle is spent before the period ends
    p_swallow_done_r1: assert property (@(posedge clk) disable iff (rst)
        boundary |-> (mode == MOD_P));

    // R5: disabled divider stays quiet
    p_quiet_off_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> !div_out);

    // R6: reset clears the output
    p_reset_low_r6: assert property (@(posedge clk)
        rst |=> !div_out);

endmodule

bind pulse_swallow_div pswal_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .div_out  (div_out),
    .boundary (boundary),
    .mode     (mode)
);

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_lo = 1'b0;
    logic       en_hi = 1'b0;
    logic [6:0] sm_lo = 7'd5;
    logic [2:0] ss_lo = 3'd0;
    logic [6:0] sm_hi = 7'd5;
    logic [4:0] ss_hi = 5'd0;
    logic       out_lo;
    logic       out_hi;

    int  n_chk  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    pulse_swallow_div #(.PRESC(8)) uut (
        .clk(clk), .rst(rst), .en(en_lo),
        .sm_val(sm_lo), .ss_val(ss_lo), .div_out(out_lo)
    );

    pulse_swallow_div #(.PRESC(32)) uut_hi (
        .clk(clk), .rst(rst), .en(en_hi),
        .sm_val(sm_hi), .ss_val(ss_hi), .div_out(out_hi)
    );

    task automatic set_vals(input bit hi, input int sm, input int ss);
        if (hi) begin
            sm_hi = 7'(sm);
            ss_hi = 5'(ss);
        end else begin
            sm_lo = 7'(sm);
            ss_lo = 3'(ss);
        end
    endtask

    // Runs one selected divider from a fresh enable for 'total' clocks,
    // comparing the output every clock against the period arithmetic.
    task automatic run_seq(input bit hi, input int sm1, input int ss1,
                           input int sm2, input int ss2, input int change_at,
                           input int total, input string tag);
        int  p;
        int  d1;
        int  d2;
        int  next;
        bit  bad;
        bit  got;
        bit  exp;
        p  = hi ? 32 : 8;
        d1 = p * sm1 + ss1;
        d2 = p * sm2 + ss2;
        @(negedge clk);
        en_lo = 1'b0;
        en_hi = 1'b0;
        set_vals(hi, sm1, ss1);
        @(negedge clk);
        n_chk++;
        if (out_lo !== 1'b0 || out_hi !== 1'b0) begin
            n_bad++;
            $display("FAIL R5 idle: actual=%b%b expected=00", out_lo, out_hi);
        end
        if (hi) en_hi = 1'b1; else en_lo = 1'b1;
        next = d1;
        bad  = 1'b0;
        for (int i = 1; i <= total; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == change_at) set_vals(hi, sm2, ss2);
            got = hi ? out_hi : out_lo;
            exp = (i == next);
            if (exp) next = next + d2;
            if (got !== exp && !bad) begin
                bad = 1'b1;
                $display("FAIL %s P=%0d SM=%0d SS=%0d clk %0d: actual=%b expected=%b",
                         tag, p, sm1, ss1, i, got, exp);
            end
        end
        n_chk++;
        if (bad) n_bad++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: output low after reset
        n_chk++;
        if (out_lo !== 1'b0 || out_hi !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 reset: actual=%b%b expected=00", out_lo, out_hi);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_lo !== 1'b0 || out_hi !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 after release: actual=%b%b expected=00", out_lo, out_hi);
        end

        // R1, R2, R3: low-band sweep
        for (int sm = 5; sm <= 20; sm++) begin
            for (int ss = 0; ss < 8; ss++) begin
                if (ss < sm) begin
                    run_seq(1'b0, sm, ss, sm, ss, 0, 2 * (8 * sm + ss) + 3,
                            (ss == 0) ? "R2" : "R1");
                end
            end
        end

        // R7: high-band pair with wider swallow field
        foreach (int_sm_list[k]) begin end
        for (int k = 0; k < 5; k++) begin
            int sm;
            sm = (k == 0) ? 5 : (k == 1) ? 6 : (k == 2) ? 7 : (k == 3) ? 64 : 127;
            for (int j = 0; j < 4; j++) begin
                int ss;
                ss = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 4 : 31;
                if (ss < sm) begin
                    run_seq(1'b1, sm, ss, sm, ss, 0, 2 * (32 * sm + ss) + 3,
                            (sm == 127 && ss == 31) ? "R8" : "R7");
                end
            end
        end

        // R8: low-band extremes
        run_seq(1'b0, 127, 7, 127, 7, 0, 2 * 1023 + 3, "R8");
        run_seq(1'b0, 127, 0, 127, 0, 0, 2 * 1016 + 3, "R8");
        run_seq(1'b0, 5, 4, 5, 4, 0, 3 * 44 + 3, "R8");

        // R4: reprogramming mid-period and one clock before the boundary
        run_seq(1'b0, 6, 2, 9, 5, 10, 50 + 3 * 77 + 2, "R4");
        run_seq(1'b0, 6, 2, 9, 5, 49, 50 + 3 * 77 + 2, "R4");
        run_seq(1'b1, 7, 3, 5, 0, 100, 227 + 2 * 160 + 2, "R4");

        // R5: drop enable mid-period, then restart counts from scratch
        run_seq(1'b0, 10, 3, 10, 3, 0, 40, "R5");
        run_seq(1'b0, 10, 3, 10, 3, 0, 2 * 83 + 3, "R5");
        run_seq(1'b1, 6, 5, 6, 5, 0, 150, "R5");
        run_seq(1'b1, 6, 5, 6, 5, 0, 2 * 197 + 3, "R5");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    int int_sm_list [1];

endmodule